// File: doc/BRIEF.md
# Four-Pool QoS Bus Arbiter

This block decides which of several bus hosts may use one shared client port, such as a memory controller. Every host is placed into one of four priority pools. A per-host enable picks where the pool number comes from: the host's own latency-QoS input, or a configured per-host priority value. A request from a higher pool always beats every request from a lower pool.

Inside a pool, a second rule picks the winner. The top pool and the bottom pool share access fairly with round-robin. The two middle pools use fixed priority. The grant is registered and is re-evaluated only when the current transfer signals completion or when no host holds the bus.

An optional keep-grant mode lets the current holder stay on the bus while it still reports transfers outstanding. This holds even when it has dropped its request during idle cycles of its final data phase.

Top module: `qos_pool_arbiter`

## Requirements
- R1: Each host's pool is a 2-bit value from 0 to 3, with 3 the most urgent. It is taken from the host's field of `qos_lvl` when that host's `qos_en` bit is 1, and from its field of `cfg_prio` when the bit is 0. Host i's field occupies bits [2i+1:2i].
- R2: On every arbitration, the winner comes from the highest pool that holds at least one request.
- R3: In pools 2 and 1, the requesting host with the lowest index wins.
- R4: Pools 3 and 0 each keep their own round-robin pointer. After reset, host 0 is the first candidate for each. A pool's pointer moves to the winner only when that pool wins. A pending pool-3 host is therefore served once every other pending pool-3 host has been served at most once.
- R5: `grant` is registered and is one-hot or all zero. It changes on the clock edge at which arbitration takes place.
- R6: While `xfer_done` is 0 and `grant` is nonzero, `grant` does not change, whatever the requests do.
- R7: Arbitration takes place on any edge where `xfer_done` is 1 or `grant` is zero. If no host is requesting at that edge, `grant` becomes zero.
- R8: With `keep_mode` 1, the current holder keeps the grant at an arbitration edge if two conditions hold: its `remaining` count is nonzero, and it has the highest pool among all hosts with a nonzero count (on a tie, the lowest index). This applies even when its request is low, and no round-robin pointer moves.
- R9: With `keep_mode` 0, `remaining` has no effect on the grant.
- R10: During reset and on the first edge after it, `grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_HOSTS | Per-host request |
| qos_lvl | input | 2*N_HOSTS | Per-host latency-QoS pool |
| cfg_prio | input | 2*N_HOSTS | Per-host configured pool |
| qos_en | input | N_HOSTS | Per-host select: 1 = use qos_lvl |
| remaining | input | CNT_W*N_HOSTS | Per-host outstanding-transfer count |
| keep_mode | input | 1 | Enables grant holding |
| xfer_done | input | 1 | Current access finished; re-arbitrate |
| grant | output | N_HOSTS | One-hot registered grant |

## Verification
The hardest case to reach is round-robin fairness in the top pool while the bottom pool's pointer must stay untouched. Reaching it needs a long run of arbitration edges with the pool assignment switched between vectors. The vector table walks both pools, interleaving them so that each pointer's position shows in the next winner. Keep-grant is reached in directed tests that first give a host the bus, then drop its request while its outstanding count stays nonzero, and then repeat this with a higher-pool host holding a nonzero count.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
  typedef logic [1:0] pool_t;
  localparam pool_t POOL_CRIT = 2'd3;
  localparam pool_t POOL_LAT  = 2'd2;
  localparam pool_t POOL_BW   = 2'd1;
  localparam pool_t POOL_BG   = 2'd0;
  localparam int    NUM_POOLS = 4;
endpackage

// File: rtl/qpa_pool_map.sv
module qpa_pool_map
  import qpa_pkg::*;
#(
  parameter int N_HOSTS = 4
) (
  input  logic [N_HOSTS-1:0]            req,
  input  logic [2*N_HOSTS-1:0]          qos_lvl,
  input  logic [2*N_HOSTS-1:0]          cfg_prio,
  input  logic [N_HOSTS-1:0]            qos_en,
  output logic [N_HOSTS-1:0][1:0]       eff_pool,
  output logic [NUM_POOLS-1:0][N_HOSTS-1:0] pool_req,
  output pool_t                         top_pool,
  output logic                          any_req
);
  for (genvar h = 0; h < N_HOSTS; h++) begin : g_host
    assign eff_pool[h] = qos_en[h] ? qos_lvl[2*h +: 2] : cfg_prio[2*h +: 2];
  end

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    for (genvar h = 0; h < N_HOSTS; h++) begin : g_member
      assign pool_req[p][h] = req[h] && (eff_pool[h] == pool_t'(p));
    end
  end

  always_comb begin
    top_pool = POOL_BG;
    any_req  = |req;
    for (int p = 0; p < NUM_POOLS; p++) begin
      if (|pool_req[p]) top_pool = pool_t'(p);
    end
  end
endmodule

// File: rtl/qpa_rr_pick.sv
module qpa_rr_pick #(
  parameter int N_HOSTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_HOSTS-1:0] cand,
  input  logic               advance,
  output logic [N_HOSTS-1:0] pick
);
  localparam int IDXW = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1;

  logic [IDXW-1:0] last_q;
  logic [IDXW-1:0] pick_idx;

  always_comb begin
    pick     = '0;
    pick_idx = last_q;
    for (int off = N_HOSTS; off >= 1; off--) begin
      int idx;
      idx = int'(last_q) + off;
      if (idx >= N_HOSTS) idx = idx - N_HOSTS;
      if (cand[idx]) begin
        pick     = '0;
        pick[idx] = 1'b1;
        pick_idx = IDXW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                last_q <= IDXW'(N_HOSTS - 1);
    else if (advance && |cand) last_q <= pick_idx;
  end
endmodule

// File: rtl/qpa_fixed_pick.sv
module qpa_fixed_pick #(
  parameter int N_HOSTS = 4
) (
  input  logic [N_HOSTS-1:0] cand,
  output logic [N_HOSTS-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int h = N_HOSTS - 1; h >= 0; h--) begin
      if (cand[h]) begin
        pick    = '0;
        pick[h] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpa_keep_select.sv
module qpa_keep_select #(
  parameter int N_HOSTS = 4,
  parameter int CNT_W   = 8
) (
  input  logic [N_HOSTS-1:0][1:0]     eff_pool,
  input  logic [CNT_W*N_HOSTS-1:0]    remaining,
  output logic [N_HOSTS-1:0]          keep_cand
);
  always_comb begin
    logic [1:0] best;
    logic       found;
    keep_cand = '0;
    best      = '0;
    found     = 1'b0;
    for (int h = 0; h < N_HOSTS; h++) begin
      if (remaining[CNT_W*h +: CNT_W] != '0) begin
        if (!found || eff_pool[h] > best) begin
          keep_cand    = '0;
          keep_cand[h] = 1'b1;
          best         = eff_pool[h];
          found        = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qos_pool_arbiter.sv
module qos_pool_arbiter
  import qpa_pkg::*;
#(
  parameter int N_HOSTS = 4,
  parameter int CNT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_HOSTS-1:0]         req,
  input  logic [2*N_HOSTS-1:0]       qos_lvl,
  input  logic [2*N_HOSTS-1:0]       cfg_prio,
  input  logic [N_HOSTS-1:0]         qos_en,
  input  logic [CNT_W*N_HOSTS-1:0]   remaining,
  input  logic                       keep_mode,
  input  logic                       xfer_done,
  output logic [N_HOSTS-1:0]         grant
);
  logic [N_HOSTS-1:0][1:0]           eff_pool;
  logic [NUM_POOLS-1:0][N_HOSTS-1:0] pool_req;
  logic [NUM_POOLS-1:0][N_HOSTS-1:0] pool_pick;
  pool_t                             top_pool;
  logic                              any_req;
  logic [N_HOSTS-1:0]                keep_cand;
  logic [N_HOSTS-1:0]                grant_q, grant_d;
  logic                              arb_ev, keep_hit;

  qpa_pool_map #(.N_HOSTS(N_HOSTS)) u_map (
    .req(req), .qos_lvl(qos_lvl), .cfg_prio(cfg_prio), .qos_en(qos_en),
    .eff_pool(eff_pool), .pool_req(pool_req), .top_pool(top_pool), .any_req(any_req)
  );

  qpa_keep_select #(.N_HOSTS(N_HOSTS), .CNT_W(CNT_W)) u_keep (
    .eff_pool(eff_pool), .remaining(remaining), .keep_cand(keep_cand)
  );

  assign arb_ev   = xfer_done || (grant_q == '0);
  assign keep_hit = keep_mode && |(keep_cand & grant_q);

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pick
    if (p == int'(POOL_CRIT) || p == int'(POOL_BG)) begin : g_rr
      logic adv;
      assign adv = arb_ev && !keep_hit && any_req && (top_pool == pool_t'(p));
      qpa_rr_pick #(.N_HOSTS(N_HOSTS)) u_rr (
        .clk(clk), .rst_n(rst_n), .cand(pool_req[p]), .advance(adv),
        .pick(pool_pick[p])
      );
    end else begin : g_fix
      qpa_fixed_pick #(.N_HOSTS(N_HOSTS)) u_fix (
        .cand(pool_req[p]), .pick(pool_pick[p])
      );
    end
  end

  always_comb begin
    grant_d = grant_q;
    if (arb_ev) begin
      if (keep_hit)     grant_d = grant_q;
      else if (any_req) grant_d = pool_pick[top_pool];
      else              grant_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  assign grant = grant_q;
endmodule

// File: rtl/qpa_checker.sv
module qpa_checker #(
  parameter int N_HOSTS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_HOSTS-1:0] req,
  input logic               keep_mode,
  input logic               xfer_done,
  input logic [N_HOSTS-1:0] grant
);
  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done && grant != '0) |=> $stable(grant));

  assert_grant_backed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_mode && (xfer_done || grant == '0)) |=> ((grant & ~$past(req)) == '0));

  assert_idle_served_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer_done || grant == '0) && req != '0) |=> (grant != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R10: assert (grant == '0 || $past(rst_n));
  end
endmodule

bind qos_pool_arbiter qpa_checker #(.N_HOSTS(N_HOSTS)) u_qpa_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .keep_mode(keep_mode),
  .xfer_done(xfer_done), .grant(grant)
);

// File: tb/qos_pool_arbiter_test.sv
module qos_pool_arbiter_test;
  localparam int N = 4;
  localparam int CW = 8;
  localparam int NV = 12;

  // {req, qos_lvl, cfg_prio, qos_en, expected grant}
  localparam logic [27:0] VEC [NV] = '{
    {4'hF, 8'h00, 8'h00, 4'h0, 4'h1},
    {4'hF, 8'h00, 8'h00, 4'h0, 4'h2},
    {4'hD, 8'h00, 8'h00, 4'h0, 4'h4},
    {4'hF, 8'h00, 8'h48, 4'h0, 4'h2},
    {4'h6, 8'h00, 8'h28, 4'h0, 4'h2},
    {4'hF, 8'hC0, 8'h00, 4'h8, 4'h8},
    {4'hF, 8'hFF, 8'h00, 4'hF, 4'h1},
    {4'hF, 8'hFF, 8'h00, 4'hF, 4'h2},
    {4'h5, 8'hFF, 8'h00, 4'hF, 4'h4},
    {4'hF, 8'h00, 8'h00, 4'h0, 4'h8},
    {4'h3, 8'h00, 8'h07, 4'h1, 4'h2},
    {4'h0, 8'h00, 8'h00, 4'h0, 4'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [2*N-1:0] qos_lvl = '0, cfg_prio = '0;
  logic [N-1:0]  qos_en = '0;
  logic [CW*N-1:0] remaining = '0;
  logic          keep_mode = 1'b0, xfer_done = 1'b0;
  logic [N-1:0]  grant;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  qos_pool_arbiter #(.N_HOSTS(N), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .qos_lvl(qos_lvl), .cfg_prio(cfg_prio),
    .qos_en(qos_en), .remaining(remaining), .keep_mode(keep_mode),
    .xfer_done(xfer_done), .grant(grant)
  );

  function automatic string vtag(int i);
    case (i)
      0, 1, 2, 9: return "R4";
      3:          return "R2";
      4:          return "R3";
      5:          return "R1";
      6, 7, 8:    return "R4";
      10:         return "R1";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] exp);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = '0; xfer_done = 1'b0; keep_mode = 1'b0; remaining = '0;
    qos_en = '0; qos_lvl = '0; cfg_prio = '0;
    step(); step();
    check("R10", '0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // first edge after reset with no request: still zero (R10)
    step();
    check("R10", '0);

    for (int i = 0; i < NV; i++) begin
      {req, qos_lvl, cfg_prio, qos_en} = VEC[i][27:4];
      xfer_done = 1'b1;
      step();
      check(vtag(i), VEC[i][3:0]);
    end

    do_reset();
    // R7: idle bus arbitrates without xfer_done
    xfer_done = 1'b0;
    req = 4'b0100;
    step();
    check("R7", 4'b0100);
    // R6: hold while transfer open
    req = 4'b1011;
    step();
    step();
    check("R6", 4'b0100);
    // R8: holder with outstanding count keeps bus despite dropped request
    keep_mode = 1'b1;
    remaining = 32'h0005_0000;
    req = 4'b0001;
    xfer_done = 1'b1;
    step();
    check("R8", 4'b0100);
    // R9: same stimulus, keep off -> count ignored
    keep_mode = 1'b0;
    step();
    check("R9", 4'b0001);
    // R8: higher-pool host with nonzero count blocks holder from keeping
    keep_mode = 1'b1;
    cfg_prio = 8'h08;
    remaining = 32'h0000_0404;
    req = 4'b0010;
    step();
    check("R8", 4'b0010);
    // R7: no requests -> grant cleared
    keep_mode = 1'b0;
    remaining = '0;
    req = '0;
    step();
    check("R7", 4'b0000);

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule